// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block links a host and an embedded controller over a 32-bit register bus. Queued work moves as 32-bit request tokens through three FIFOs. A free list holds controller-side request slots and is preloaded at reset. A post queue carries requests from the host to the controller. A completion queue carries finished requests back to the host.

The host reads the inbound port to claim a free slot and writes the same address to post a request. The controller takes posted tokens over a valid/ready pair and hands back completed tokens over a second pair. The host then reads completions from the outbound port. It writes that port to give a controller slot back to the free list.

A token with bit 31 set names a request in host memory. Its low 31 bits are the bus address shifted right by five, so such requests sit on 32-byte boundaries. A token with bit 31 clear is an offset into controller memory.

Non-queued commands go through message registers, a doorbell, and two interrupt status/mask pairs. A two-state command tracker watches for completion of a command written to inbound message 0. The tracker is in `CMD_IDLE` until the host writes inbound message 0, which takes it to `CMD_WAIT`. Another write to inbound message 0 while in `CMD_WAIT` re-arms it with the new value and keeps it there. A controller outbound-message write whose value equals the armed value returns it to `CMD_IDLE` and raises the command-done status bit.

Top module: `qmu_top`

## Requirements
- R1: After reset:
  - inbound status (0x24) and outbound status (0x30) read 0;
  - the inbound mask (0x28) reads 0x3 and the outbound mask (0x34) reads 0x1F;
  - both queues are empty;
  - the free list holds DEPTH slots, SLOT_BASE + i*SLOT_STEP for i = 0 to DEPTH-1.
- R2: A host read of 0x40 pops the oldest free slot. Read data appears on `bus_rdata` in the cycle after the read strobe. A read while the free list is empty returns 0xFFFFFFFF and removes nothing.
- R3: A host write to 0x40 posts a token. The controller receives posted tokens in order through `post_valid`/`post_ready`, and the token holds steady while it waits. A post to a full queue is dropped and sets sticky outbound status bit 2.
- R4: The controller completes a token through `done_valid`/`done_ready`. `done_ready` is low while the completion queue is full. Each accepted completion sets outbound status bit 0. Host reads of 0x44 return completions in order, and a read of an empty queue returns 0xFFFFFFFF.
- R5: A host write to 0x44 whose bit 31 is clear returns that slot to the free list. A write with bit 31 set is ignored. A return to a full free list is dropped and sets sticky outbound status bit 3.
- R6: The controller-side message and doorbell registers behave as follows:
  - Inbound messages 0 and 1 (0x10, 0x14) are visible to the controller.
  - A write to 0x10 sets inbound status bit 0.
  - A write to the doorbell (0x20) ORs its data into the doorbell, and nonzero data sets inbound status bit 1.
  - The controller clears doorbell bits with `ctl_db_clr` and status bits with `ctl_iclr`.
- R7: `ctl_irq` is high exactly when some inbound status bit is set and its inbound mask bit is 0.
- R8: A controller outbound-message write updates outbound message 0 or 1 (read at 0x18/0x1C) and sets outbound status bit 1. In `CMD_WAIT`, a value equal to the armed command also sets outbound status bit 4 and returns the tracker to `CMD_IDLE`.
- R9: Writing 1 to a bit at 0x30 clears that status bit, and a set in the same cycle wins. `host_irq` is high exactly when some outbound status bit is set and its mask bit at 0x34 is 0.
- R10: Register offsets are fixed:

  | Offset | Register |
  |---|---|
  | 0x10 | inbound message 0 |
  | 0x14 | inbound message 1 |
  | 0x18 | outbound message 0 |
  | 0x1C | outbound message 1 |
  | 0x20 | doorbell |
  | 0x24 | inbound status |
  | 0x28 | inbound mask |
  | 0x30 | outbound status |
  | 0x34 | outbound mask |
  | 0x40 | inbound port |
  | 0x44 | outbound port |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| host_irq | output | 1 | Outbound interrupt to host |
| post_valid | output | 1 | Posted token available |
| post_ready | input | 1 | Controller takes posted token |
| post_token | output | 32 | Oldest posted token |
| done_valid | input | 1 | Controller offers a completion |
| done_ready | output | 1 | Completion queue has room |
| done_token | input | 32 | Completed token |
| ctl_imsg0 | output | 32 | Inbound message 0 |
| ctl_imsg1 | output | 32 | Inbound message 1 |
| ctl_doorbell | output | 32 | Doorbell bits |
| ctl_istat | output | 2 | Inbound status (bit 0 message, bit 1 doorbell) |
| ctl_iclr | input | 2 | Clear inbound status bits |
| ctl_db_clr | input | 32 | Clear doorbell bits |
| ctl_irq | output | 1 | Inbound interrupt to controller |
| ctl_omsg_we | input | 1 | Controller writes an outbound message |
| ctl_omsg_sel | input | 1 | Selects outbound message 0 or 1 |
| ctl_omsg_data | input | 32 | Outbound message value |

## Verification
Two conditions are hardest to reach from the ports: a full post queue while the controller stalls, and a full free list receiving a returned slot.

The bench holds `post_ready` low while it posts one token more than the queue depth. It then lets the queue drain against a scoreboard and confirms that the extra token never arrives.

The free list is already full right after reset, so a slot return at that point shows the overflow bit. The bench then empties the list through reads until the 0xFFFFFFFF marker appears. This shows that neither empty reads nor returns of host-memory tokens add an entry.

// File: rtl/qmu_pkg.sv
package qmu_pkg;
    localparam int unsigned TOK_W = 32;
    typedef logic [TOK_W-1:0] token_t;

    localparam logic [7:0] OFF_IMSG0 = 8'h10;
    localparam logic [7:0] OFF_IMSG1 = 8'h14;
    localparam logic [7:0] OFF_OMSG0 = 8'h18;
    localparam logic [7:0] OFF_OMSG1 = 8'h1C;
    localparam logic [7:0] OFF_DBELL = 8'h20;
    localparam logic [7:0] OFF_ISTAT = 8'h24;
    localparam logic [7:0] OFF_IMASK = 8'h28;
    localparam logic [7:0] OFF_OSTAT = 8'h30;
    localparam logic [7:0] OFF_OMASK = 8'h34;
    localparam logic [7:0] OFF_INQ   = 8'h40;
    localparam logic [7:0] OFF_OUTQ  = 8'h44;

    localparam token_t EMPTY_TOKEN = '1;

    localparam int unsigned IST_W        = 2;
    localparam int unsigned IST_MSG      = 0;
    localparam int unsigned IST_DB       = 1;

    localparam int unsigned OST_W        = 5;
    localparam int unsigned OST_NOTEMPTY = 0;
    localparam int unsigned OST_NEWMSG   = 1;
    localparam int unsigned OST_POST_OVF = 2;
    localparam int unsigned OST_FREE_OVF = 3;
    localparam int unsigned OST_CMD_DONE = 4;

    localparam int unsigned HOST_TAG_BIT = 31;

    typedef enum logic [0:0] {
        CMD_IDLE = 1'b0,
        CMD_WAIT = 1'b1
    } cmd_state_e;
endpackage

// File: rtl/qmu_fifo.sv
module qmu_fifo #(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned W        = 32,
    parameter bit          PRELOAD  = 1'b0,
    parameter logic [W-1:0] PRE_BASE = '0,
    parameter logic [W-1:0] PRE_STEP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CNT_FULL);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= PRELOAD ? CNT_FULL : '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    generate
        if (PRELOAD) begin : g_preload
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(DEPTH); i++)
                        mem[i] <= PRE_BASE + PRE_STEP * W'(i);
                end else if (push_ok) begin
                    mem[wr_ptr] <= din;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (push_ok) mem[wr_ptr] <= din;
            end
        end
    endgenerate
endmodule

// File: rtl/qmu_cmd_fsm.sv
module qmu_cmd_fsm
    import qmu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   arm,
    input  token_t arm_value,
    input  logic   reply,
    input  token_t reply_value,
    output logic   done
);
    cmd_state_e state_q, state_d;
    token_t     pend_q;
    logic       match;

    assign match = reply && (reply_value == pend_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) pend_q <= arm_value;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (arm) state_d = CMD_WAIT;
            CMD_WAIT: begin
                if (arm)        state_d = CMD_WAIT;
                else if (match) state_d = CMD_IDLE;
            end
            default:  state_d = CMD_IDLE;
        endcase
    end

    always_comb begin
        done = 1'b0;
        unique case (state_q)
            CMD_IDLE: done = 1'b0;
            CMD_WAIT: done = !arm && match;
            default:  done = 1'b0;
        endcase
    end
endmodule

// File: rtl/qmu_top.sv
module qmu_top
    import qmu_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter logic [31:0] SLOT_BASE = 32'h0000_1000,
    parameter logic [31:0] SLOT_STEP = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        host_irq,
    output logic        post_valid,
    input  logic        post_ready,
    output logic [31:0] post_token,
    input  logic        done_valid,
    output logic        done_ready,
    input  logic [31:0] done_token,
    output logic [31:0] ctl_imsg0,
    output logic [31:0] ctl_imsg1,
    output logic [31:0] ctl_doorbell,
    output logic [1:0]  ctl_istat,
    input  logic [1:0]  ctl_iclr,
    input  logic [31:0] ctl_db_clr,
    output logic        ctl_irq,
    input  logic        ctl_omsg_we,
    input  logic        ctl_omsg_sel,
    input  logic [31:0] ctl_omsg_data
);
    logic rd_stb, wr_stb;
    assign rd_stb = bus_en && !bus_we;
    assign wr_stb = bus_en && bus_we;

    // Free slot list, preloaded
    logic   free_empty, free_full, free_pop, free_push;
    token_t free_head;
    // Post queue (host -> controller)
    logic   post_empty, post_full, post_push, post_pop;
    // Completion queue (controller -> host)
    logic   done_empty, done_full, done_pop, done_push;
    token_t done_head;

    assign free_pop  = rd_stb && (bus_addr == OFF_INQ) && !free_empty;
    assign done_pop  = rd_stb && (bus_addr == OFF_OUTQ) && !done_empty;
    assign post_push = wr_stb && (bus_addr == OFF_INQ);
    assign free_push = wr_stb && (bus_addr == OFF_OUTQ) && !bus_wdata[HOST_TAG_BIT];
    assign post_pop  = post_valid && post_ready;
    assign done_push = done_valid && done_ready;

    assign post_valid = !post_empty;
    assign done_ready = !done_full;

    qmu_fifo #(.DEPTH(DEPTH), .W(TOK_W), .PRELOAD(1'b1),
               .PRE_BASE(SLOT_BASE), .PRE_STEP(SLOT_STEP)) u_free (
        .clk(clk), .rst_n(rst_n), .push(free_push), .din(bus_wdata),
        .pop(free_pop), .head(free_head), .full(free_full), .empty(free_empty));

    qmu_fifo #(.DEPTH(DEPTH), .W(TOK_W)) u_post (
        .clk(clk), .rst_n(rst_n), .push(post_push), .din(bus_wdata),
        .pop(post_pop), .head(post_token), .full(post_full), .empty(post_empty));

    qmu_fifo #(.DEPTH(DEPTH), .W(TOK_W)) u_done (
        .clk(clk), .rst_n(rst_n), .push(done_push), .din(done_token),
        .pop(done_pop), .head(done_head), .full(done_full), .empty(done_empty));

    // Non-queued command tracker
    logic cmd_done;
    qmu_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n),
        .arm(wr_stb && (bus_addr == OFF_IMSG0)), .arm_value(bus_wdata),
        .reply(ctl_omsg_we), .reply_value(ctl_omsg_data),
        .done(cmd_done));

    // Message, doorbell, status and mask registers
    token_t            imsg0_q, imsg1_q, omsg0_q, omsg1_q, dbell_q;
    logic [IST_W-1:0]  istat_q, imask_q, istat_set;
    logic [OST_W-1:0]  ostat_q, omask_q, ostat_set, ostat_clr;

    always_comb begin
        istat_set          = '0;
        istat_set[IST_MSG] = wr_stb && (bus_addr == OFF_IMSG0);
        istat_set[IST_DB]  = wr_stb && (bus_addr == OFF_DBELL) && (bus_wdata != '0);

        ostat_set               = '0;
        ostat_set[OST_NOTEMPTY] = done_push;
        ostat_set[OST_NEWMSG]   = ctl_omsg_we;
        ostat_set[OST_POST_OVF] = post_push && post_full;
        ostat_set[OST_FREE_OVF] = free_push && free_full;
        ostat_set[OST_CMD_DONE] = cmd_done;

        ostat_clr = (wr_stb && (bus_addr == OFF_OSTAT)) ? bus_wdata[OST_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imsg0_q <= '0;
            imsg1_q <= '0;
            omsg0_q <= '0;
            omsg1_q <= '0;
            dbell_q <= '0;
            istat_q <= '0;
            imask_q <= '1;
            ostat_q <= '0;
            omask_q <= '1;
        end else begin
            if (wr_stb && bus_addr == OFF_IMSG0) imsg0_q <= bus_wdata;
            if (wr_stb && bus_addr == OFF_IMSG1) imsg1_q <= bus_wdata;
            if (wr_stb && bus_addr == OFF_IMASK) imask_q <= bus_wdata[IST_W-1:0];
            if (wr_stb && bus_addr == OFF_OMASK) omask_q <= bus_wdata[OST_W-1:0];
            if (ctl_omsg_we && !ctl_omsg_sel) omsg0_q <= ctl_omsg_data;
            if (ctl_omsg_we &&  ctl_omsg_sel) omsg1_q <= ctl_omsg_data;
            dbell_q <= (dbell_q & ~ctl_db_clr)
                     | ((wr_stb && bus_addr == OFF_DBELL) ? bus_wdata : '0);
            istat_q <= (istat_q & ~ctl_iclr) | istat_set;
            ostat_q <= (ostat_q & ~ostat_clr) | ostat_set;
        end
    end

    // Read path, registered
    token_t rd_val;
    always_comb begin
        unique case (bus_addr)
            OFF_IMSG0: rd_val = imsg0_q;
            OFF_IMSG1: rd_val = imsg1_q;
            OFF_OMSG0: rd_val = omsg0_q;
            OFF_OMSG1: rd_val = omsg1_q;
            OFF_DBELL: rd_val = dbell_q;
            OFF_ISTAT: rd_val = 32'(istat_q);
            OFF_IMASK: rd_val = 32'(imask_q);
            OFF_OSTAT: rd_val = 32'(ostat_q);
            OFF_OMASK: rd_val = 32'(omask_q);
            OFF_INQ:   rd_val = free_empty ? EMPTY_TOKEN : free_head;
            OFF_OUTQ:  rd_val = done_empty ? EMPTY_TOKEN : done_head;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_val;
    end

    assign ctl_imsg0    = imsg0_q;
    assign ctl_imsg1    = imsg1_q;
    assign ctl_doorbell = dbell_q;
    assign ctl_istat    = istat_q;
    assign ctl_irq      = |(istat_q & ~imask_q);
    assign host_irq     = |(ostat_q & ~omask_q);
endmodule

// File: rtl/qmu_checker.sv
module qmu_checker
    import qmu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             post_valid,
    input logic             post_ready,
    input logic [31:0]      post_token,
    input logic             ctl_irq,
    input logic [1:0]       ctl_istat,
    input logic             ctl_omsg_we,
    input logic [OST_W-1:0] ostat_q,
    input logic             free_empty,
    input logic             done_empty
);
    p_empty_free_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == OFF_INQ && free_empty) |=> (bus_rdata == EMPTY_TOKEN));

    p_post_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && !post_ready) |=> (post_valid && $stable(post_token)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ostat_q[OST_POST_OVF] && !(bus_en && bus_we && bus_addr == OFF_OSTAT && bus_wdata[OST_POST_OVF]))
        |=> ostat_q[OST_POST_OVF]);

    p_empty_done_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == OFF_OUTQ && done_empty) |=> (bus_rdata == EMPTY_TOKEN));

    p_ctl_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq |-> (ctl_istat != '0));

    p_cmd_done_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ostat_q[OST_CMD_DONE]) |-> $past(ctl_omsg_we));
endmodule

bind qmu_top qmu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .post_valid(post_valid), .post_ready(post_ready), .post_token(post_token),
    .ctl_irq(ctl_irq), .ctl_istat(ctl_istat), .ctl_omsg_we(ctl_omsg_we),
    .ostat_q(ostat_q), .free_empty(free_empty), .done_empty(done_empty)
);

// File: tb/qmu_top_test.sv
module qmu_top_test;
    localparam int DEPTH = 16;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [31:0] STEP = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        host_irq, post_valid, post_ready = 1'b0;
    logic [31:0] post_token;
    logic        done_valid = 1'b0, done_ready;
    logic [31:0] done_token = '0;
    logic [31:0] ctl_imsg0, ctl_imsg1, ctl_doorbell;
    logic [1:0]  ctl_istat, ctl_iclr = '0;
    logic [31:0] ctl_db_clr = '0;
    logic        ctl_irq, ctl_omsg_we = 1'b0, ctl_omsg_sel = 1'b0;
    logic [31:0] ctl_omsg_data = '0;

    int checks = 0, fails = 0;
    logic [31:0] exp_post[$];
    logic [31:0] exp_done[$];

    always #10 clk = ~clk;

    qmu_top #(.DEPTH(DEPTH), .SLOT_BASE(BASE), .SLOT_STEP(STEP)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bread(a, d);
        check(req, d, exp);
    endtask

    task automatic post(input logic [31:0] tok, input bit expect_accept);
        if (expect_accept) exp_post.push_back(tok);
        bwrite(8'h40, tok);
    endtask

    task automatic complete(input logic [31:0] tok);
        @(negedge clk);
        check("R4 done_ready before push", 32'(done_ready), 32'd1);
        done_valid = 1'b1; done_token = tok;
        exp_done.push_back(tok);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic host_pop_completion();
        logic [31:0] d;
        bread(8'h44, d);
        if (exp_done.size() == 0) check("R4 unexpected completion", d, 32'hFFFF_FFFF);
        else check("R4 completion order", d, exp_done.pop_front());
    endtask

    task automatic ctl_msg(input logic sel, input logic [31:0] v);
        @(negedge clk);
        ctl_omsg_we = 1'b1; ctl_omsg_sel = sel; ctl_omsg_data = v;
        @(negedge clk);
        ctl_omsg_we = 1'b0;
    endtask

    // Monitor: compares posted tokens as the controller takes them (R3)
    always begin
        @(negedge clk);
        #2;
        if (rst_n && post_valid && post_ready) begin
            if (exp_post.size() == 0) check("R3 unexpected post", post_token, 32'hFFFF_FFFF);
            else check("R3 post order", post_token, exp_post.pop_front());
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check("R1 istat", 8'h24, 32'h0);
        read_check("R1 ostat", 8'h30, 32'h0);
        read_check("R1 imask", 8'h28, 32'h3);
        read_check("R1 omask", 8'h34, 32'h1F);
        check("R1 post_valid", 32'(post_valid), 32'd0);
        check("R1 done_ready", 32'(done_ready), 32'd1);

        // R5 return to a full free list
        bwrite(8'h44, BASE);
        read_check("R5 free overflow bit3", 8'h30, 32'h8);
        bwrite(8'h30, 32'h8);
        read_check("R9 w1c clears", 8'h30, 32'h0);

        // R2 free slots in order, then empty marker without side effect
        for (int i = 0; i < DEPTH; i++)
            read_check("R2 free slot", 8'h40, BASE + STEP * 32'(i));
        read_check("R2 empty read", 8'h40, 32'hFFFF_FFFF);
        read_check("R2 empty read again", 8'h40, 32'hFFFF_FFFF);

        // R5 host-memory tag ignored, controller slot returned
        bwrite(8'h44, 32'h8000_0040);
        read_check("R5 host token ignored", 8'h40, 32'hFFFF_FFFF);
        read_check("R5 no overflow on ignore", 8'h30, 32'h0);
        bwrite(8'h44, 32'h0000_1500);
        read_check("R5 slot returned", 8'h40, 32'h0000_1500);

        // R3 post queue with stalled controller, overflow, then drain
        post_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i[0]) post(32'h8000_0000 | ((32'h0010_0000 + 32'(i) * 32'h40) >> 5), 1'b1);
            else      post(BASE + STEP * 32'(i), 1'b1);
        end
        post(32'hDEAD_0000, 1'b0);
        read_check("R3 post overflow bit2", 8'h30, 32'h4);
        @(negedge clk);
        check("R3 post_valid while stalled", 32'(post_valid), 32'd1);
        check("R3 head token", post_token, exp_post[0]);
        post_ready = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        check("R3 all posts delivered", 32'(exp_post.size()), 32'd0);
        check("R3 dropped token absent", 32'(post_valid), 32'd0);
        bwrite(8'h30, 32'h4);

        // R4 / R9 completion and host interrupt
        bwrite(8'h34, 32'hFFFF_FFFE);
        @(negedge clk);
        check("R9 irq low before completion", 32'(host_irq), 32'd0);
        complete(32'h8000_0010);
        check("R9 irq on completion", 32'(host_irq), 32'd1);
        read_check("R4 notempty bit0", 8'h30, 32'h1);
        host_pop_completion();
        read_check("R4 empty outbound", 8'h44, 32'hFFFF_FFFF);
        check("R9 irq sticky", 32'(host_irq), 32'd1);
        bwrite(8'h30, 32'h1);
        check("R9 irq cleared", 32'(host_irq), 32'd0);

        // R4 full completion queue
        for (int i = 0; i < DEPTH; i++) complete(32'h0000_2000 + 32'(i));
        @(negedge clk);
        check("R4 done_ready low when full", 32'(done_ready), 32'd0);
        for (int i = 0; i < DEPTH; i++) host_pop_completion();
        check("R4 scoreboard drained", 32'(exp_done.size()), 32'd0);
        bwrite(8'h30, 32'h1F);

        // R6 / R7 inbound messages and doorbell
        bwrite(8'h28, 32'hFFFF_FFFC);
        check("R7 ctl_irq idle", 32'(ctl_irq), 32'd0);
        bwrite(8'h10, 32'hC0DE_0001);
        check("R6 imsg0", ctl_imsg0, 32'hC0DE_0001);
        check("R6 istat bit0", 32'(ctl_istat), 32'h1);
        check("R7 ctl_irq on msg", 32'(ctl_irq), 32'd1);
        bwrite(8'h14, 32'h77);
        check("R6 imsg1", ctl_imsg1, 32'h77);
        @(negedge clk);
        ctl_iclr = 2'b01;
        @(negedge clk);
        ctl_iclr = 2'b00;
        check("R6 istat cleared", 32'(ctl_istat), 32'h0);
        check("R7 ctl_irq cleared", 32'(ctl_irq), 32'd0);
        bwrite(8'h20, 32'h5);
        bwrite(8'h20, 32'h2);
        check("R6 doorbell OR", ctl_doorbell, 32'h7);
        check("R6 istat bit1", 32'(ctl_istat), 32'h2);
        @(negedge clk);
        ctl_db_clr = 32'h1;
        @(negedge clk);
        ctl_db_clr = '0;
        read_check("R6 doorbell after clear", 8'h20, 32'h6);
        read_check("R6 istat host view", 8'h24, 32'h2);
        bwrite(8'h28, 32'h3);
        check("R7 masked", 32'(ctl_irq), 32'd0);

        // R8 command tracker (armed with C0DE0001)
        ctl_msg(1'b0, 32'h0000_1234);
        read_check("R8 new msg, no match", 8'h30, 32'h2);
        read_check("R8 omsg0", 8'h18, 32'h0000_1234);
        check("R9 masked bit1", 32'(host_irq), 32'd0);
        ctl_msg(1'b1, 32'hC0DE_0001);
        read_check("R8 command done", 8'h30, 32'h12);
        read_check("R8 omsg1", 8'h1C, 32'hC0DE_0001);
        bwrite(8'h30, 32'h12);
        ctl_msg(1'b1, 32'hC0DE_0001);
        read_check("R8 idle no done", 8'h30, 32'h2);

        // R10 offsets: message 1 read-back at its own offset
        read_check("R10 imsg1 offset", 8'h14, 32'h77);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule